// File: doc/BRIEF.md
# Video Memory Block Copy Controller

This controller copies data from anywhere in the address map into the 8 KiB video memory window at 0x8000–0x9FFF. Software sets it up through five byte registers: two for the source address, two for the destination address, and one control byte. The control byte sets both the transfer length and the mode. A copy always moves whole 16-byte blocks. Each byte takes one read cycle and then one write cycle. The CPU is held stalled while a block is being copied.

The controller has two modes, chosen by bit 7 of the control byte:

- **Bulk mode.** The whole requested length is copied at once.
- **Blank-paced mode.** One block is copied each time the display enters its horizontal blank. The control byte counts down the blocks still to go. The CPU can cancel a pending blank-paced sequence by writing the control byte again with bit 7 clear.

The block is driven by the register write port, the LCD-enable level, the current video mode, and a single-cycle pulse that marks entry into video mode 0. It drives a byte-wide memory read/write port and a CPU stall line.

Top module: `vram_dma`

## Requirements
- R1: After reset the controller is idle. The stall line and both memory strobes are low, and the control register (select 4) reads 0xFF.
- R2: The source address is the source high/low registers (select 0/1) with bits 3:0 cleared. If this address falls in 0x8000–0x9FFF, a control write is rejected: no transfer starts, and the control register reads the written value with bit 7 set. A source of 0xA000 is accepted.
- R3: The destination address is (dest & 0x1FF0) | 0x8000, where dest is the destination high/low registers (select 2/3). As it advances, the destination wraps within 0x8000–0x9FFF.
- R4: A control write with bit 7 = 0, made while no blank-paced sequence is pending, copies (bits 6:0 + 1) × 16 bytes at once. The stall line is high for the whole copy, and the control register reads 0xFF afterwards.
- R5: Each byte takes two cycles. In the first, memRdEn is high and the address is the source pointer. In the next, memWrEn is high, the address is the destination pointer, and the write data is the byte just read. Both pointers then increment.
- R6: At the end of each 16-byte block, the source and destination registers read back the advanced pointer values.
- R7: A control write with bit 7 = 1, made while lcdOn = 1 and vidMode = 0, copies one block at once. The control register holds bits 6:0 of the written value, then decrements by one when that block ends.
- R8: While a blank-paced sequence is pending, each blankStart pulse with lcdOn = 1 copies exactly one block, and the control register then decrements. When it wraps to 0xFF the sequence ends and later pulses copy nothing. Pulses arriving while lcdOn = 0 copy nothing.
- R9: A control write with bit 7 = 0, made while a blank-paced sequence is pending (and not in LCD-on mode 0), cancels the sequence. The control register reads the written value with bit 7 clear, and later pulses copy nothing.
- R10: A control write with bit 7 = 1, made while lcdOn = 0, leaves the sequence pending. The control register reads 0x80 | ((value + 1) & 0x7F).
- R11: A control write with bit 7 = 1, made while lcdOn = 1 and vidMode ≠ 0, leaves the sequence pending with no immediate copy. The control register reads bits 6:0 of the written value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe (ignored while stalled) |
| regSel | input | 3 | Write select: 0 src hi, 1 src lo, 2 dst hi, 3 dst lo, 4 control |
| regWrData | input | 8 | Register write data |
| rdSel | input | 3 | Read-back select, same encoding as regSel |
| rdData | output | 8 | Read-back value of the selected register (0xFF for unused selects) |
| lcdOn | input | 1 | LCD enable level |
| vidMode | input | 2 | Current video mode |
| blankStart | input | 1 | One-cycle pulse on entry to video mode 0 |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| memAddr | output | 16 | Memory address for the current read or write |
| memWrData | output | 8 | Memory write data |
| memRdData | input | 8 | Memory read data, valid in the same cycle as memRdEn |
| cpuStall | output | 1 | CPU hold while a block is being copied |

## Verification
The hardest states to reach from the ports are the ones where the control byte is rewritten while a blank-paced sequence is already pending. The same written value can start a copy, leave the sequence pending, or cancel it. Which one happens depends on the LCD enable and the video mode at the moment of the write.

The stimulus walks the sequence through these states in order:
1. It parks a sequence as pending by writing with the LCD off, and separately by writing in a non-blank mode.
2. It advances the sequence one block per blank pulse, including a pulse sent while the LCD is off.
3. It cancels the sequence from the pending state.
4. It pulses again to show that the cancelled sequence stays dead.

One block is aimed at the top of the video window, so that the destination wrap appears in the written-back registers.

// File: rtl/vram_dma_pkg.sv
package vram_dma_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RD   = 2'd1,
    ST_WR   = 2'd2
  } dmaState_e;

  // Strobes from the control FSM to the address/data path
  typedef struct packed {
    logic latch;    // capture masked source/destination into the pointers
    logic start;    // load the byte counter from the block count
    logic rdPhase;  // read cycle of a byte
    logic wrPhase;  // write cycle of a byte
  } dmaStrobe_t;

endpackage

// File: rtl/vram_dma_path.sv
module vram_dma_path
  import vram_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 16,
  parameter int MAXBLK_W    = 8,
  parameter int WIN_W       = 13,
  parameter logic [ADDR_W-1:0] WIN_BASE = 16'h8000
) (
  input  logic              clk,
  input  logic              rstN,
  input  dmaStrobe_t        strobe,
  input  logic [MAXBLK_W-1:0] blkCount,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic [ADDR_W-1:0] srcReg,
  output logic [ADDR_W-1:0] dstReg,
  output logic [ADDR_W-1:0] srcMasked,
  output logic              lastByte,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData
);
  localparam int BLK_LSB = $clog2(BLOCK_BYTES);
  localparam int REM_W   = MAXBLK_W + BLK_LSB;
  localparam logic [ADDR_W-1:0] WIN_MASK  = ADDR_W'((1 << WIN_W) - 1);
  localparam logic [ADDR_W-1:0] ALIGN_MSK = ~ADDR_W'(BLOCK_BYTES - 1);

  logic [ADDR_W-1:0] srcPtr, dstPtr, dstMasked, dstNext, srcNext;
  logic [REM_W-1:0]  remBytes;
  logic [DATA_W-1:0] dataBuf;
  logic              blockEnd;

  assign srcMasked = srcReg & ALIGN_MSK;
  assign dstMasked = (dstReg & WIN_MASK & ALIGN_MSK) | WIN_BASE;
  assign srcNext   = srcPtr + 1'b1;
  assign dstNext   = (dstPtr & ~WIN_MASK) | ((dstPtr + 1'b1) & WIN_MASK);

  assign lastByte  = (remBytes == REM_W'(1));
  assign blockEnd  = strobe.wrPhase && (remBytes[BLK_LSB-1:0] == BLK_LSB'(1));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcReg   <= '0;
      dstReg   <= '0;
      srcPtr   <= '0;
      dstPtr   <= WIN_BASE;
      remBytes <= '0;
      dataBuf  <= '0;
    end else begin
      if (regWrEn) begin
        case (regSel)
          3'd0: srcReg[ADDR_W-1:DATA_W] <= regWrData;
          3'd1: srcReg[DATA_W-1:0]      <= regWrData;
          3'd2: dstReg[ADDR_W-1:DATA_W] <= regWrData;
          3'd3: dstReg[DATA_W-1:0]      <= regWrData;
          default: ;
        endcase
      end
      if (strobe.latch) begin
        srcPtr <= srcMasked;
        dstPtr <= dstMasked;
      end
      if (strobe.start) begin
        remBytes <= {blkCount, {BLK_LSB{1'b0}}};
      end
      if (strobe.rdPhase) begin
        dataBuf <= memRdData;
      end
      if (strobe.wrPhase) begin
        srcPtr   <= srcNext;
        dstPtr   <= dstNext;
        remBytes <= remBytes - 1'b1;
        if (blockEnd) begin
          srcReg <= srcNext;
          dstReg <= dstNext;
        end
      end
    end
  end

  assign memRdEn   = strobe.rdPhase;
  assign memWrEn   = strobe.wrPhase;
  assign memAddr   = strobe.wrPhase ? dstPtr : srcPtr;
  assign memWrData = dataBuf;

endmodule

// File: rtl/vram_dma_ctrl.sv
module vram_dma_ctrl
  import vram_dma_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 8,
  parameter int MAXBLK_W = 8,
  parameter int CTRL_SEL = 4,
  parameter logic [ADDR_W-1:0] REJ_LO = 16'h8000,
  parameter logic [ADDR_W-1:0] REJ_HI = 16'hA000
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                regWrEn,
  input  logic [2:0]          regSel,
  input  logic [DATA_W-1:0]   regWrData,
  input  logic                lcdOn,
  input  logic [1:0]          vidMode,
  input  logic                blankStart,
  input  logic [ADDR_W-1:0]   srcMasked,
  input  logic                lastByte,
  output dmaStrobe_t          strobe,
  output logic [MAXBLK_W-1:0] blkCount,
  output logic [DATA_W-1:0]   ctrlReg,
  output logic                cpuStall
);
  localparam int LEN_W = DATA_W - 1;

  dmaState_e         state;
  logic              hActive, curH;
  logic              wrCtrl, inVram, rejected, goNow, pulseGo, startAny, newH;
  logic [LEN_W-1:0]  lenField;
  logic              blankWindow;

  assign newH        = regWrData[DATA_W-1];
  assign lenField    = regWrData[LEN_W-1:0];
  assign inVram      = (srcMasked >= REJ_LO) && (srcMasked < REJ_HI);
  assign blankWindow = lcdOn && (vidMode == 2'd0);
  assign wrCtrl      = regWrEn && (regSel == 3'(CTRL_SEL)) && (state == ST_IDLE);
  assign rejected    = wrCtrl && inVram;
  assign goNow       = wrCtrl && !inVram && ((!hActive && !newH) || blankWindow);
  assign pulseGo     = !wrCtrl && (state == ST_IDLE) && hActive && blankStart && lcdOn;
  assign startAny    = goNow || pulseGo;

  always_comb begin
    if (goNow && !newH) blkCount = MAXBLK_W'({1'b0, lenField}) + 1'b1;
    else                blkCount = MAXBLK_W'(1);
  end

  always_comb begin
    strobe.latch   = wrCtrl && !inVram;
    strobe.start   = startAny;
    strobe.rdPhase = (state == ST_RD);
    strobe.wrPhase = (state == ST_WR);
  end

  assign cpuStall = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      hActive <= 1'b0;
      curH    <= 1'b0;
      ctrlReg <= '1;
    end else begin
      case (state)
        ST_IDLE: if (startAny) state <= ST_RD;
        ST_RD:   state <= ST_WR;
        ST_WR:   state <= lastByte ? ST_IDLE : ST_RD;
        default: state <= ST_IDLE;
      endcase

      if (rejected) begin
        ctrlReg <= {1'b1, lenField};
      end else if (wrCtrl) begin
        hActive <= newH;
        curH    <= newH;
        if (goNow)              ctrlReg <= {1'b0, lenField};
        else if (newH && !lcdOn) ctrlReg <= {1'b1, lenField + 1'b1};
        else                     ctrlReg <= {1'b0, lenField};
      end else if (pulseGo) begin
        curH <= 1'b1;
      end

      if (state == ST_WR && lastByte) begin
        if (curH) begin
          ctrlReg <= ctrlReg - 1'b1;
          if (ctrlReg == '0) hActive <= 1'b0;
        end else begin
          ctrlReg <= '1;
        end
      end
    end
  end

endmodule

// File: rtl/vram_dma.sv
module vram_dma
  import vram_dma_pkg::*;
#(
  parameter int ADDR_W      = 16,
  parameter int DATA_W      = 8,
  parameter int BLOCK_BYTES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWrEn,
  input  logic [2:0]        regSel,
  input  logic [DATA_W-1:0] regWrData,
  input  logic [2:0]        rdSel,
  output logic [DATA_W-1:0] rdData,
  input  logic              lcdOn,
  input  logic [1:0]        vidMode,
  input  logic              blankStart,
  output logic              memRdEn,
  output logic              memWrEn,
  output logic [ADDR_W-1:0] memAddr,
  output logic [DATA_W-1:0] memWrData,
  input  logic [DATA_W-1:0] memRdData,
  output logic              cpuStall
);
  localparam int MAXBLK_W = DATA_W;

  dmaStrobe_t          strobe;
  logic [MAXBLK_W-1:0] blkCount;
  logic [DATA_W-1:0]   ctrlReg;
  logic [ADDR_W-1:0]   srcReg, dstReg, srcMasked;
  logic                lastByte;

  vram_dma_ctrl #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MAXBLK_W(MAXBLK_W)
  ) u_ctrl (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .lcdOn(lcdOn), .vidMode(vidMode), .blankStart(blankStart),
    .srcMasked(srcMasked), .lastByte(lastByte),
    .strobe(strobe), .blkCount(blkCount), .ctrlReg(ctrlReg), .cpuStall(cpuStall)
  );

  vram_dma_path #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .BLOCK_BYTES(BLOCK_BYTES), .MAXBLK_W(MAXBLK_W)
  ) u_path (
    .clk(clk), .rstN(rstN),
    .strobe(strobe), .blkCount(blkCount),
    .regWrEn(regWrEn && !cpuStall), .regSel(regSel), .regWrData(regWrData),
    .memRdData(memRdData),
    .srcReg(srcReg), .dstReg(dstReg), .srcMasked(srcMasked), .lastByte(lastByte),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr), .memWrData(memWrData)
  );

  always_comb begin
    case (rdSel)
      3'd0:    rdData = srcReg[ADDR_W-1:DATA_W];
      3'd1:    rdData = srcReg[DATA_W-1:0];
      3'd2:    rdData = dstReg[ADDR_W-1:DATA_W];
      3'd3:    rdData = dstReg[DATA_W-1:0];
      3'd4:    rdData = ctrlReg;
      default: rdData = '1;
    endcase
  end

endmodule

// File: rtl/vram_dma_chk.sv
module vram_dma_chk #(
  parameter int ADDR_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              memRdEn,
  input logic              memWrEn,
  input logic [ADDR_W-1:0] memAddr,
  input logic              cpuStall
);
  logic [ADDR_W-1:0] lastRdAddr;

  always_ff @(posedge clk) begin
    if (!rstN)        lastRdAddr <= '0;
    else if (memRdEn) lastRdAddr <= memAddr;
  end

  assert_rd_wr_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    !(memRdEn && memWrEn));

  assert_rd_then_wr_R5: assert property (@(posedge clk) disable iff (!rstN)
    memRdEn |=> memWrEn);

  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> $past(memRdEn));

  assert_src_step_R5: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn && $past(memWrEn)) |-> (memAddr == lastRdAddr + 1'b1));

  assert_dst_window_R3: assert property (@(posedge clk) disable iff (!rstN)
    memWrEn |-> (memAddr[ADDR_W-1:ADDR_W-3] == 3'b100));

  assert_stall_cover_R4: assert property (@(posedge clk) disable iff (!rstN)
    (memRdEn || memWrEn) |-> cpuStall);

  assert_end_on_write_R4: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuStall) |-> $past(memWrEn));

endmodule

bind vram_dma vram_dma_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rstN(rstN), .memRdEn(memRdEn), .memWrEn(memWrEn),
  .memAddr(memAddr), .cpuStall(cpuStall)
);

// File: tb/sim_vram_dma.sv
module sim_vram_dma;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic [2:0]  regSel = 3'd0;
  logic [7:0]  regWrData = 8'd0;
  logic [2:0]  rdSel = 3'd4;
  logic [7:0]  rdData;
  logic        lcdOn = 1'b0;
  logic [1:0]  vidMode = 2'd0;
  logic        blankStart = 1'b0;
  logic        memRdEn, memWrEn, cpuStall;
  logic [15:0] memAddr;
  logic [7:0]  memWrData, memRdData;

  int checks = 0;
  int fails  = 0;
  bit finished = 1'b0;

  always #10 clk = ~clk;

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'h3C;
  endfunction

  assign memRdData = pat(memAddr);

  vram_dma u0 (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regSel(regSel), .regWrData(regWrData),
    .rdSel(rdSel), .rdData(rdData), .lcdOn(lcdOn), .vidMode(vidMode),
    .blankStart(blankStart), .memRdEn(memRdEn), .memWrEn(memWrEn), .memAddr(memAddr),
    .memWrData(memWrData), .memRdData(memRdData), .cpuStall(cpuStall)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [2:0] sel, input logic [7:0] val);
    regSel = sel; regWrData = val; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic readReg(input logic [2:0] sel, input logic [7:0] exp, input string req);
    rdSel = sel;
    #1;
    check(rdData == exp, req, rdData, exp);
  endtask

  task automatic setAddr(input logic [15:0] src, input logic [15:0] dst);
    writeReg(3'd0, src[15:8]); writeReg(3'd1, src[7:0]);
    writeReg(3'd2, dst[15:8]); writeReg(3'd3, dst[7:0]);
  endtask

  task automatic pulse();
    blankStart = 1'b1;
    @(negedge clk);
    blankStart = 1'b0;
  endtask

  // Expects a copy of n bytes starting now; src/dst already masked.
  task automatic runXfer(input logic [15:0] src, input logic [15:0] dst, input int n,
                         input string req);
    int bad = 0;
    int firstBad = -1;
    for (int i = 0; i < n; i++) begin
      logic [15:0] s, d;
      s = src + 16'(i);
      d = 16'h8000 | ((dst + 16'(i)) & 16'h1FFF);
      if (!(memRdEn && !memWrEn && cpuStall && memAddr == s)) begin
        bad++; if (firstBad < 0) firstBad = i;
      end
      @(negedge clk);
      if (!(memWrEn && !memRdEn && cpuStall && memAddr == d && memWrData == pat(s))) begin
        bad++; if (firstBad < 0) firstBad = i;
      end
      @(negedge clk);
    end
    check(bad == 0, {req, " byte stream"}, firstBad, -1);
    check(!cpuStall && !memRdEn && !memWrEn, {req, " idle after copy"}, cpuStall, 0);
  endtask

  task automatic expectQuiet(input int n, input string req);
    int busy = 0;
    for (int i = 0; i < n; i++) begin
      if (memRdEn || memWrEn || cpuStall) busy++;
      @(negedge clk);
    end
    check(busy == 0, {req, " no transfer"}, busy, 0);
  endtask

  task automatic testReset();
    check(!cpuStall && !memRdEn && !memWrEn, "R1 idle strobes", cpuStall, 0);
    readReg(3'd4, 8'hFF, "R1 control reset value");
  endtask

  task automatic testBulk();
    setAddr(16'h1234, 16'h8F57);
    writeReg(3'd4, 8'h01);
    runXfer(16'h1230, 16'h8F50, 32, "R4 R2 R3 R5 bulk 32 bytes");
    readReg(3'd4, 8'hFF, "R4 control after bulk");
    readReg(3'd0, 8'h12, "R6 src hi");
    readReg(3'd1, 8'h50, "R6 src lo");
    readReg(3'd2, 8'h8F, "R6 dst hi");
    readReg(3'd3, 8'h70, "R6 dst lo");
  endtask

  task automatic testReject();
    setAddr(16'h9FFF, 16'h0000);
    writeReg(3'd4, 8'h10);
    expectQuiet(40, "R2 vram source");
    readReg(3'd4, 8'h90, "R2 reject readback");
  endtask

  task automatic testBlankRun();
    lcdOn = 1'b1; vidMode = 2'd0;
    setAddr(16'hC000, 16'h0000);
    writeReg(3'd4, 8'h82);
    runXfer(16'hC000, 16'h8000, 16, "R7 immediate block");
    readReg(3'd4, 8'h01, "R7 control after first block");
    lcdOn = 1'b0;
    pulse();
    expectQuiet(40, "R8 pulse with lcd off");
    lcdOn = 1'b1;
    pulse();
    runXfer(16'hC010, 16'h8010, 16, "R8 second block");
    readReg(3'd4, 8'h00, "R8 control after second block");
    expectQuiet(10, "R8 one block per pulse");
    pulse();
    runXfer(16'hC020, 16'h8020, 16, "R8 third block");
    readReg(3'd4, 8'hFF, "R8 control wrapped");
    readReg(3'd1, 8'h30, "R6 src lo after blank blocks");
    readReg(3'd3, 8'h30, "R6 dst lo after blank blocks");
    pulse();
    expectQuiet(40, "R8 sequence ended");
  endtask

  task automatic testPendingCancel();
    lcdOn = 1'b1; vidMode = 2'd2;
    setAddr(16'h4000, 16'h1FFF);
    writeReg(3'd4, 8'h85);
    expectQuiet(20, "R11 pending in mode 2");
    readReg(3'd4, 8'h05, "R11 readback");
    pulse();
    runXfer(16'h4000, 16'h9FF0, 16, "R3 block at window top");
    readReg(3'd4, 8'h04, "R8 decrement");
    readReg(3'd2, 8'h80, "R3 dst wraps hi");
    readReg(3'd3, 8'h00, "R3 dst wraps lo");
    writeReg(3'd4, 8'h05);
    expectQuiet(20, "R9 cancel write");
    readReg(3'd4, 8'h05, "R9 cancel readback");
    pulse();
    expectQuiet(40, "R9 pulse after cancel");
  endtask

  task automatic testLcdOff();
    lcdOn = 1'b0; vidMode = 2'd0;
    setAddr(16'h0100, 16'h0200);
    writeReg(3'd4, 8'h83);
    expectQuiet(20, "R10 lcd off pending");
    readReg(3'd4, 8'h84, "R10 readback");
    lcdOn = 1'b1;
    pulse();
    runXfer(16'h0100, 16'h8200, 16, "R10 block after lcd on");
    readReg(3'd4, 8'h83, "R10 decrement");
    vidMode = 2'd2;
    writeReg(3'd4, 8'h00);
    readReg(3'd4, 8'h00, "R9 cancel readback zero");
    pulse();
    expectQuiet(40, "R9 cancelled stays idle");
  endtask

  task automatic testLongBulk();
    setAddr(16'hA000, 16'h0000);
    writeReg(3'd4, 8'h7F);
    runXfer(16'hA000, 16'h8000, 2048, "R4 R2 max length from 0xA000");
    readReg(3'd4, 8'hFF, "R4 control after max bulk");
    readReg(3'd0, 8'hA8, "R6 src hi after max");
    readReg(3'd2, 8'h88, "R6 dst hi after max");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    testReset();
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBulk();
    testReject();
    testBlankRun();
    testPendingCancel();
    testLcdOff();
    testLongBulk();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule